// File: doc/BRIEF.md
# Fall-Through FIFO Controller with Programmable Level Flags

This block is the control logic of a FIFO, together with a small inferred storage array. Pointers advance inside the block and are never supplied from outside. Writes are taken on the write clock and reads on the read clock. A build parameter selects one of two clocking schemes:

- Two independent clocks. The pointers then cross between domains in Gray code through two-flop synchronizers.
- A single shared clock. Both clock inputs are tied together and the pointers are compared directly.

Data width is the same on both sides.

The block produces four level flags: full, empty, almost full and almost empty. Both almost thresholds are ordinary inputs and can be changed at any time. Rejected accesses produce one-cycle error pulses.

The `fall_through` input selects how words reach the reader:

- Standard mode. A word is delivered one read-clock cycle after the read request is accepted.
- Fall-through mode. The oldest stored word is moved into the output stage without any request. A read then consumes that word and refills the output stage.

The read side holds a two-state output machine:

- States: `OUT_IDLE` means the output stage is empty. `OUT_HOLD` means it presents a word.
- Transitions:
  - *prefetch*: `OUT_IDLE` to `OUT_HOLD` when fall-through is selected and the array holds a word.
  - *refill*: `OUT_HOLD` to `OUT_HOLD` on a read while the array still holds a word.
  - *keep*: `OUT_HOLD` to `OUT_HOLD` when no read is requested.
  - *drain*: `OUT_HOLD` to `OUT_IDLE` on a read with the array empty.
  - *stay*: `OUT_IDLE` to `OUT_IDLE` in standard mode or with the array empty.

Top module: `fifo_fwft_ctl`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `rd_valid`=0, `overflow`=0 and `underflow`=0. `almost_empty` is 1 whenever `ae_level` is 0 or more.
- R2: `full` is 1 exactly when the storage array holds 2^ADDR_W words, counted from the write-side pointers.
- R3: A write while `full` is 1 is ignored. It stores nothing and raises `overflow` for exactly the following write-clock cycle.
- R4: A read while `empty` is 1 is ignored. It raises `underflow` for exactly the following read-clock cycle. In standard mode, `empty` is 1 exactly when the array holds no word.
- R5: `almost_full` is 1 exactly when the number of words in the array is at least `af_level`.
- R6: `almost_empty` is 1 exactly when the occupancy is at most `ae_level`. Occupancy is the words in the array plus one if the output stage holds a word.
- R7: In standard mode (`fall_through`=0), an accepted read loads the oldest word into `rd_data`. `rd_valid` is 1 for the one read-clock cycle that follows. Words come out in write order.
- R8: In fall-through mode (`fall_through`=1), the oldest word is moved to `rd_data` without a read, one read-clock cycle after it is visible in the array. `rd_valid`=1 and `empty`=0 while the output stage holds a word. The word stays stable until it is read. A read takes it and presents the next one in the same edge. Total capacity is 2^ADDR_W+1 words.
- R9: A write and a read in the same cycle, with the FIFO neither full nor empty, are both accepted. Occupancy is unchanged and order is kept.
- R10: `fall_through` may be changed while the FIFO is completely empty. The new mode applies from the next read-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| af_level | input | ADDR_W+1 | Almost-full threshold in words |
| full | output | 1 | Array holds 2^ADDR_W words |
| almost_full | output | 1 | Array count at or above `af_level` |
| overflow | output | 1 | One-cycle pulse after a rejected write |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Read request |
| fall_through | input | 1 | 1 selects fall-through mode, 0 standard mode |
| ae_level | input | ADDR_W+1 | Almost-empty threshold in words |
| rd_data | output | DATA_W | Output word |
| rd_valid | output | 1 | `rd_data` holds a delivered word |
| empty | output | 1 | No word available to read |
| almost_empty | output | 1 | Occupancy at or below `ae_level` |
| underflow | output | 1 | One-cycle pulse after a rejected read |

## Verification
Several events can land in the same cycle:

- A write and a read together.
- A rejected write while a read frees a slot. The write must still be refused, because `full` was 1 at that edge.
- A write into a drained fall-through FIFO while a read is rejected.
- A read that drains the output stage while a new word is reaching the array.

The bench provokes these with long runs of simultaneous requests around both ends of the range and with random traffic under narrow thresholds. Every cycle it compares each flag, pulse and delivered word against a queue-based model that applies rejection before insertion. Fall-through and standard phases alternate, and each mode switch is made with the FIFO empty.

// File: rtl/fifo_fwft_pkg.sv
package fifo_fwft_pkg;
    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_HOLD = 1'b1
    } out_state_e;
endpackage

// File: rtl/fifo_ptr_xing.sv
module fifo_ptr_xing #(
    parameter int AW       = 4,
    parameter bit DUAL_CLK = 1
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [AW:0]   src_ptr,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [AW:0]   dst_ptr
);
    generate
        if (DUAL_CLK) begin : g_gray
            logic [AW:0] gray_q, sync1_q, sync2_q;
            always_ff @(posedge src_clk or negedge src_rst_n) begin
                if (!src_rst_n) gray_q <= '0;
                else            gray_q <= src_ptr ^ (src_ptr >> 1);
            end
            always_ff @(posedge dst_clk or negedge dst_rst_n) begin
                if (!dst_rst_n) begin
                    sync1_q <= '0;
                    sync2_q <= '0;
                end else begin
                    sync1_q <= gray_q;
                    sync2_q <= sync1_q;
                end
            end
            always_comb begin
                dst_ptr[AW] = sync2_q[AW];
                for (int i = AW - 1; i >= 0; i--) dst_ptr[i] = dst_ptr[i+1] ^ sync2_q[i];
            end
        end else begin : g_direct
            assign dst_ptr = src_ptr;
        end
    endgenerate
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
    parameter int AW = 4
) (
    input  logic        wclk,
    input  logic        wrst_n,
    input  logic        wr_en,
    input  logic [AW:0] af_level,
    input  logic [AW:0] rptr_w,
    output logic [AW:0] wptr,
    output logic        we,
    output logic        full,
    output logic        almost_full,
    output logic        overflow
);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(1 << AW);
    logic [AW:0] count;

    assign count       = wptr - rptr_w;
    assign full        = (count == DEPTH_C);
    assign we          = wr_en && !full;
    assign almost_full = (count >= af_level);

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wptr     <= '0;
            overflow <= 1'b0;
        end else begin
            if (we) wptr <= wptr + 1'b1;
            overflow <= wr_en && full;
        end
    end

    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && full) |=> (wptr == $past(wptr)));
    a_r2_count_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
        count <= DEPTH_C);
    a_r5_full_implies_af: assert property (@(posedge wclk) disable iff (!wrst_n)
        (full && af_level <= DEPTH_C) |-> almost_full);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import fifo_fwft_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    input  logic          fall_through,
    input  logic [AW:0]   ae_level,
    input  logic [AW:0]   wptr_r,
    input  logic [W-1:0]  mem_data,
    output logic [AW:0]   rptr,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic          empty,
    output logic          almost_empty,
    output logic          underflow
);
    out_state_e  state_q, state_d;
    logic [AW:0] mem_cnt;
    logic        mem_has, pop, std_vld_q, unf_q;
    logic [AW+1:0] occ;

    assign mem_cnt = wptr_r - rptr;
    assign mem_has = (mem_cnt != '0);
    assign pop = fall_through ? (mem_has && (state_q == OUT_IDLE || rd_en)) : (rd_en && mem_has);
    assign occ = {1'b0, mem_cnt} + {{(AW+1){1'b0}}, (state_q == OUT_HOLD)};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: if (fall_through && mem_has) state_d = OUT_HOLD;
            OUT_HOLD: if (rd_en && !mem_has)       state_d = OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            state_q   <= OUT_IDLE;
            rptr      <= '0;
            rd_data   <= '0;
            std_vld_q <= 1'b0;
            unf_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            std_vld_q <= !fall_through && rd_en && mem_has;
            unf_q     <= rd_en && (fall_through ? (state_q == OUT_IDLE) : !mem_has);
            if (pop) begin
                rd_data <= mem_data;
                rptr    <= rptr + 1'b1;
            end
        end
    end

    always_comb begin
        empty        = fall_through ? (state_q == OUT_IDLE) : !mem_has;
        rd_valid     = fall_through ? (state_q == OUT_HOLD) : std_vld_q;
        almost_empty = (occ <= {1'b0, ae_level});
        underflow    = unf_q;
    end

    a_r4_empty_read_ignored: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!fall_through && rd_en && empty) |=> $stable(rptr));
    a_r7_std_valid_pulse: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!fall_through && rd_en && !empty) |=> (rd_valid || fall_through));
    a_r8_hold_stable: assert property (@(posedge rclk) disable iff (!rrst_n)
        (fall_through && state_q == OUT_HOLD && !rd_en) |=> (rd_valid && $stable(rd_data)));
    a_r8_valid_not_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
        fall_through |-> (rd_valid != empty));
endmodule

// File: rtl/fifo_fwft_ctl.sv
module fifo_fwft_ctl #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter bit DUAL_CLK = 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W:0]   af_level,
    output logic              full,
    output logic              almost_full,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              fall_through,
    input  logic [ADDR_W:0]   ae_level,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              almost_empty,
    output logic              underflow
);
    logic [ADDR_W:0]   wptr, rptr, wptr_r, rptr_w;
    logic              we;
    logic [DATA_W-1:0] mem_q;

    fifo_wr_side #(.AW(ADDR_W)) u_wr (
        .wclk(wr_clk), .wrst_n(wr_rst_n), .wr_en(wr_en), .af_level(af_level),
        .rptr_w(rptr_w), .wptr(wptr), .we(we), .full(full),
        .almost_full(almost_full), .overflow(overflow)
    );

    fifo_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(wptr[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rptr[ADDR_W-1:0]), .rdata(mem_q)
    );

    fifo_ptr_xing #(.AW(ADDR_W), .DUAL_CLK(DUAL_CLK)) u_w2r (
        .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_ptr(wptr),
        .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_ptr(wptr_r)
    );

    fifo_ptr_xing #(.AW(ADDR_W), .DUAL_CLK(DUAL_CLK)) u_r2w (
        .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_ptr(rptr),
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_ptr(rptr_w)
    );

    fifo_rd_side #(.W(DATA_W), .AW(ADDR_W)) u_rd (
        .rclk(rd_clk), .rrst_n(rd_rst_n), .rd_en(rd_en), .fall_through(fall_through),
        .ae_level(ae_level), .wptr_r(wptr_r), .mem_data(mem_q), .rptr(rptr),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .almost_empty(almost_empty), .underflow(underflow)
    );
endmodule

// File: tb/sim_fifo_fwft_ctl.sv
`timescale 1ns/1ps
module sim_fifo_fwft_ctl;
    localparam int W = 8;
    localparam int AW = 4;
    localparam int D = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, ft = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [AW:0] af_lvl = 5'd12, ae_lvl = 5'd3;
    logic full, almost_full, overflow, rd_valid, empty, almost_empty, underflow;
    logic [W-1:0] rd_data;

    always #2.5 clk = ~clk;

    fifo_fwft_ctl #(.DATA_W(W), .ADDR_W(AW), .DUAL_CLK(1'b0)) u0 (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .af_level(af_lvl),
        .full(full), .almost_full(almost_full), .overflow(overflow),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .fall_through(ft), .ae_level(ae_lvl),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .almost_empty(almost_empty), .underflow(underflow)
    );

    int total = 0, bad = 0;
    bit finished = 1'b0, live = 1'b0;
    string phase = "R1 reset";

    // behavioural reference: queue of stored words plus output-stage word
    logic [W-1:0] mq[$];
    bit h = 0, sv = 0, mo = 0, mu = 0;
    logic [W-1:0] hw = '0, sd = '0;
    int n;
    bit fullp;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); h = 0; sv = 0; mo = 0; mu = 0;
        end else begin
            n = mq.size();
            fullp = (n == D);
            mo = wr_en && fullp;
            sv = 0;
            if (ft) begin
                mu = rd_en && !h;
                if (!h) begin
                    if (n > 0) begin hw = mq.pop_front(); h = 1; end
                end else if (rd_en) begin
                    if (n > 0) hw = mq.pop_front();
                    else h = 0;
                end
            end else begin
                mu = rd_en && (n == 0);
                if (rd_en && n > 0) begin sd = mq.pop_front(); sv = 1; end
            end
            if (wr_en && !fullp) mq.push_back(wr_data);
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && rst_n && !finished) begin
            check(full == (mq.size() == D), "R2 full", full, mq.size() == D);
            check(overflow == mo, "R3 overflow", overflow, mo);
            check(underflow == mu, "R4 underflow", underflow, mu);
            check(empty == (ft ? !h : (mq.size() == 0)), "R4/R8 empty", empty, ft ? !h : (mq.size() == 0));
            check(almost_full == (mq.size() >= af_lvl), "R5 almost_full", almost_full, mq.size() >= af_lvl);
            check(almost_empty == ((mq.size() + int'(h)) <= ae_lvl), "R6 almost_empty",
                  almost_empty, (mq.size() + int'(h)) <= ae_lvl);
            check(rd_valid == (ft ? h : sv), "R7/R8 rd_valid", rd_valid, ft ? h : sv);
            if (rd_valid && (ft ? h : sv))
                check(rd_data == (ft ? hw : sd), "R7/R8 rd_data", rd_data, ft ? hw : sd);
        end
    end

    task automatic step(input bit w, input logic [W-1:0] d, input bit r);
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk); #1;
    endtask

    task automatic drain();
        while (mq.size() != 0 || h) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(empty === 1'b1, "R1 empty", empty, 1);
        check(full === 1'b0, "R1 full", full, 0);
        check(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
        check(overflow === 1'b0 && underflow === 1'b0, "R1 pulses", {overflow, underflow}, 0);
        check(almost_empty === 1'b1, "R1 almost_empty", almost_empty, 1);
        @(posedge clk); #1;
        rst_n = 1'b1; live = 1'b1;

        phase = "R2 R3 R7 standard fill";
        for (int i = 0; i < D + 3; i++) step(1'b1, W'(8'h10 + i), 1'b0);
        phase = "R3 full with read";
        step(1'b1, 8'hEE, 1'b1);
        phase = "R4 R7 standard drain";
        for (int i = 0; i < D + 3; i++) step(1'b0, '0, 1'b1);

        phase = "R9 simultaneous standard";
        for (int i = 0; i < 8; i++) step(1'b1, W'(8'h40 + i), 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, W'(8'h60 + i), 1'b1);
        drain();

        phase = "R10 switch to fall-through";
        ft = 1'b1;
        step(1'b0, '0, 1'b0);
        phase = "R8 single word prefetch";
        step(1'b1, 8'hA5, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        phase = "R8 R2 fall-through capacity";
        for (int i = 0; i < D + 4; i++) step(1'b1, W'(8'h80 + i), 1'b0);
        phase = "R9 simultaneous fall-through";
        for (int i = 0; i < 12; i++) step(1'b1, W'(8'hC0 + i), 1'b1);
        phase = "R4 R8 fall-through drain";
        for (int i = 0; i < D + 4; i++) step(1'b0, '0, 1'b1);
        phase = "R8 write into empty while reading";
        step(1'b1, 8'h5A, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);

        phase = "R5 R6 narrow thresholds fall-through";
        af_lvl = 5'd1; ae_lvl = 5'd0;
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 9) < 6), W'($urandom), 1'($urandom_range(0, 9) < 4));
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 9) < 4), W'($urandom), 1'($urandom_range(0, 9) < 6));
        drain();

        phase = "R10 switch to standard";
        ft = 1'b0;
        af_lvl = 5'd16; ae_lvl = 5'd15;
        step(1'b0, '0, 1'b0);
        phase = "R5 R6 R9 random standard";
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 9) < 6), W'($urandom), 1'($urandom_range(0, 9) < 5));
        af_lvl = 5'd0; ae_lvl = 5'd16;
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 9) < 4), W'($urandom), 1'($urandom_range(0, 9) < 6));
        drain();
        finish_run();
    end
endmodule